// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block gathers four interrupt request lines into a sticky pending register and qualifies each pending bit with its own mask bit held in a software-written mask register. A fixed priority encoder reduces the qualified requests to a two-bit source index and an "any request" status flag. Line 0 has the highest priority and line 3 the lowest. The interrupt line to the processor is raised when the global enable flag is set and at least one qualified request exists.

When the processor answers with an acknowledge, the block presents an 8-bit vector. The upper six bits come from a programmable base register and the lower two bits carry the encoded index. The vector is frozen on the rising edge of the acknowledge, so a request that arrives during the acknowledge cannot disturb it. The data output is enabled only while the acknowledge is high. At all other times it reads zero, and its output-enable signal stands in for a high-impedance bus driver. Software reaches the block through a one-cycle write port. A 3-bit command selects what the 6-bit data word updates.

Top module: `prio_intr_ctrl`

## Requirements
- R1: After reset, int_req, int_status and vec_oe are 0 and vec_data is 8'h00. The pending register, the mask register, the enable flag and the vector base are all cleared.
- R2: A high level on irq_src[k] sets pending bit k at the next clock edge. The bit stays set after the line returns low.
- R3: Command 3'd3 clears every pending bit k for which wr_data[k] is 1. Bits with wr_data[k]=0 are unchanged. If the line requests in the same cycle as its clear, the request wins and the bit stays set.
- R4: Command 3'd1 sets the mask bits selected by wr_data[3:0], and command 3'd2 clears them. A pending bit whose mask bit is 0 does not count as a request, but it is kept and counts again once its mask bit is set.
- R5: int_status is 1 exactly when some pending bit has its mask bit set.
- R6: The index is 0 when qualified bit 0 is set. Otherwise it is 1 if bit 1 is set, otherwise 2 if bit 2 is set, otherwise 3. Source 0 wins over every other source.
- R7: int_req equals enable AND int_status. Command 3'd0 with wr_data[0]=1 sets the enable flag, and with wr_data[0]=0 clears it.
- R8: vec_oe is high in exactly the cycles in which int_ack is high. While int_ack is low, vec_data is 8'h00.
- R9: vec_data = {base[5:0], index[1:0]}. Command 3'd4 loads base from wr_data[5:0]. With base 0, source 3 alone gives 8'h03.
- R10: The vector is captured on the rising edge of int_ack and held for as long as int_ack stays high, even if a higher-priority request arrives meanwhile.
- R11: Commands 3'd5, 3'd6 and 3'd7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 4 | Request lines, bit 0 highest priority |
| wr_en | input | 1 | Command strobe, one cycle per command |
| wr_sel | input | 3 | Command code |
| wr_data | input | 6 | Command operand |
| int_ack | input | 1 | Processor acknowledge |
| int_req | output | 1 | Interrupt to processor |
| int_status | output | 1 | Any qualified request present |
| vec_data | output | 8 | Vector address, valid while vec_oe is high |
| vec_oe | output | 1 | Bus driver enable for vec_data |

## Verification
The hardest case to reach is a change of the winning source during an acknowledge. It needs a low-priority request to be pending and unmasked, the acknowledge to be already high, and then a request on line 0 to land one cycle into the acknowledge. The stimulus sets up line 3 alone, raises the acknowledge, and pulses line 0 in the following cycle. It then checks that the vector still names line 3, and that a fresh acknowledge then names line 0. A second narrow case pairs a clear command with a new request on the same line in the same cycle.

// File: rtl/prio_intr_pkg.sv
// Package: shared constants and command codes for the priority interrupt controller.
// Assumes four request sources and an 8-bit vector, changeable through parameters.
package prio_intr_pkg;
    localparam int NUM_SRC  = 4;
    localparam int VECTOR_W = 8;
    localparam int CMD_W    = 3;

    // Write-port command codes
    typedef enum logic [CMD_W-1:0] {
        CMD_ENABLE   = 3'd0,
        CMD_MASK_SET = 3'd1,
        CMD_MASK_CLR = 3'd2,
        CMD_PEND_CLR = 3'd3,
        CMD_BASE     = 3'd4
    } cmd_e;
endpackage

// File: rtl/pic_req_bank.sv
// Module: pending and mask registers.
// Does: latches request levels into sticky pending bits and applies per-bit masks.
// Assumes: request lines are synchronous to clk; a request beats a same-cycle clear.
module pic_req_bank
    import prio_intr_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  irq_src,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_sel,
    input  logic [NSRC-1:0]  wr_bits,
    output logic [NSRC-1:0]  qualified
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] clr_bits;
    logic            mset, mclr;

    // Decode which write commands target this bank
    always_comb begin
        mset     = wr_en && (wr_sel == CMD_MASK_SET);
        mclr     = wr_en && (wr_sel == CMD_MASK_CLR);
        clr_bits = (wr_en && (wr_sel == CMD_PEND_CLR)) ? wr_bits : '0;
    end

    // Pending register: clear selected bits, then OR in new requests
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_bits) | irq_src;
    end

    // Mask register: set or clear selected bits
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (mset) mask_q <= mask_q | wr_bits;
        else if (mclr) mask_q <= mask_q & ~wr_bits;
    end

    // Qualified requests seen by the encoder
    always_comb qualified = pend_q & mask_q;

    p_req_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_src) |=> ((pend_q & $past(irq_src)) == $past(irq_src)));

    p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == CMD_PEND_CLR && irq_src == '0) |=> ((pend_q & $past(wr_bits)) == '0));

    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == CMD_MASK_SET) |=> ((mask_q & $past(wr_bits)) == $past(wr_bits)));

    p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == CMD_MASK_CLR) |=> ((mask_q & $past(wr_bits)) == '0));
endmodule

// File: rtl/pic_encoder.sv
// Module: fixed priority encoder.
// Does: reduces qualified requests to an index (lowest bit wins) and an any-request flag.
// Assumes: the index is don't-care when no request is present.
module pic_encoder #(
    parameter int NSRC  = 4,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  qualified,
    output logic [IDX_W-1:0] idx,
    output logic             any_req
);
    // Any-request flag
    always_comb any_req = |qualified;

    generate
        if (NSRC == 4) begin : g_four
            logic bit_x, bit_y;
            // Two-level logic for four sources
            always_comb begin
                bit_x = ~qualified[0] & ~qualified[1];
                bit_y = (~qualified[0] & qualified[1]) | (~qualified[0] & ~qualified[2]);
                idx   = {bit_x, bit_y};
            end
        end else begin : g_generic
            // Scan from lowest priority up so the lowest set bit wins
            always_comb begin
                idx = IDX_W'(NSRC - 1);
                for (int k = NSRC - 1; k >= 0; k--) begin
                    if (qualified[k]) idx = IDX_W'(k);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pic_ctrl_regs.sv
// Module: global enable flag and vector base register.
// Does: updates the enable flag and the base from write commands.
// Assumes: one command per write cycle.
module pic_ctrl_regs
    import prio_intr_pkg::*;
#(
    parameter int BASE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_sel,
    input  logic [BASE_W-1:0] wr_data,
    output logic              ien,
    output logic [BASE_W-1:0] base
);
    // Enable flag follows bit 0 of the enable command
    always_ff @(posedge clk) begin
        if (!rst_n)                             ien <= 1'b0;
        else if (wr_en && wr_sel == CMD_ENABLE) ien <= wr_data[0];
    end

    // Base register loaded by the base command
    always_ff @(posedge clk) begin
        if (!rst_n)                           base <= '0;
        else if (wr_en && wr_sel == CMD_BASE) base <= wr_data;
    end

    p_ien_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_sel == CMD_ENABLE)) |=> $stable(ien));

    p_base_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_sel == CMD_BASE)) |=> $stable(base));
endmodule

// File: rtl/pic_vector.sv
// Module: acknowledge and vector output.
// Does: shows the live vector in the first acknowledge cycle, captures it at the
// rising edge of acknowledge and holds it until acknowledge falls.
// Assumes: the bus driver is external; vec_oe models its enable.
module pic_vector #(
    parameter int VEC_W = 8,
    parameter int IDX_W = 2,
    parameter int BASE_W = VEC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_ack,
    input  logic [BASE_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [VEC_W-1:0]  vec_data,
    output logic              vec_oe
);
    logic             ack_q;
    logic [VEC_W-1:0] held_q;
    logic [VEC_W-1:0] live;

    // Vector formed from the current base and index
    always_comb live = {base, idx};

    // Track acknowledge and capture on its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            held_q <= '0;
        end else begin
            ack_q <= int_ack;
            if (int_ack && !ack_q) held_q <= live;
        end
    end

    // Drive the bus only during acknowledge
    always_comb begin
        vec_oe   = int_ack;
        vec_data = !int_ack ? '0 : (ack_q ? held_q : live);
    end

    p_vec_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && $past(int_ack)) |-> $stable(vec_data));

    p_bus_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |-> (!vec_oe && vec_data == '0));
endmodule

// File: rtl/prio_intr_ctrl.sv
// Module: top of the masked parallel priority interrupt controller.
// Does: connects the request bank, encoder, control registers and vector unit.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module prio_intr_ctrl
    import prio_intr_pkg::*;
#(
    parameter int NSRC   = NUM_SRC,
    parameter int VEC_W  = VECTOR_W,
    parameter int IDX_W  = $clog2(NSRC),
    parameter int BASE_W = VEC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_sel,
    input  logic [BASE_W-1:0] wr_data,
    input  logic              int_ack,
    output logic              int_req,
    output logic              int_status,
    output logic [VEC_W-1:0]  vec_data,
    output logic              vec_oe
);
    logic [NSRC-1:0]   qualified;
    logic [IDX_W-1:0]  idx;
    logic              ien;
    logic [BASE_W-1:0] base;

    pic_req_bank #(.NSRC(NSRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_bits(wr_data[NSRC-1:0]), .qualified(qualified)
    );

    pic_encoder #(.NSRC(NSRC), .IDX_W(IDX_W)) u_enc (
        .qualified(qualified), .idx(idx), .any_req(int_status)
    );

    pic_ctrl_regs #(.BASE_W(BASE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ien(ien), .base(base)
    );

    pic_vector #(.VEC_W(VEC_W), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_vec (
        .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .base(base), .idx(idx),
        .vec_data(vec_data), .vec_oe(vec_oe)
    );

    // Processor interrupt gated by the global enable
    always_comb int_req = ien & int_status;

    p_req_has_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> int_status);

    p_top_source_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        qualified[0] |-> (idx == '0));

    p_status_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (qualified == '0) |-> !int_status);
endmodule

// File: tb/prio_intr_ctrl_test.sv
`timescale 1ns/1ps
module prio_intr_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq_src = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [5:0] wr_data = '0;
    logic       int_ack = 1'b0;
    logic       int_req, int_status, vec_oe;
    logic [7:0] vec_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    prio_intr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .int_ack(int_ack),
        .int_req(int_req), .int_status(int_status),
        .vec_data(vec_data), .vec_oe(vec_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] sel, input logic [5:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [3:0] src);
        @(negedge clk);
        irq_src = src;
        @(negedge clk);
        irq_src = '0;
    endtask

    // Raise acknowledge, read the live vector, then the held one, then drop
    task automatic ack_read(input string tag, input logic [7:0] exp);
        @(negedge clk);
        int_ack = 1'b1;
        #1;
        check({tag, " oe"}, {7'd0, vec_oe}, 8'h01);
        check({tag, " live"}, vec_data, exp);
        @(negedge clk);
        check({tag, " held"}, vec_data, exp);
        int_ack = 1'b0;
        #1;
        check({tag, " idle R8"}, vec_data, 8'h00);
    endtask

    task automatic t_reset;
        check("R1 int_req", {7'd0, int_req}, 8'h00);
        check("R1 int_status", {7'd0, int_status}, 8'h00);
        check("R1 vec_oe", {7'd0, vec_oe}, 8'h00);
        check("R1 vec_data", vec_data, 8'h00);
    endtask

    task automatic t_latch;
        cmd(3'd1, 6'h0F);
        pulse(4'b0100);
        check("R2 sticky status R5", {7'd0, int_status}, 8'h01);
        check("R7 no req while disabled", {7'd0, int_req}, 8'h00);
        cmd(3'd3, 6'b000100);
        check("R3 cleared", {7'd0, int_status}, 8'h00);
    endtask

    task automatic t_mask;
        cmd(3'd2, 6'b000010);
        pulse(4'b0010);
        check("R4 masked off", {7'd0, int_status}, 8'h00);
        cmd(3'd1, 6'b000010);
        check("R4 kept pending", {7'd0, int_status}, 8'h01);
        cmd(3'd3, 6'h0F);
        check("R3 clear all", {7'd0, int_status}, 8'h00);
    endtask

    task automatic t_ien;
        pulse(4'b1000);
        cmd(3'd0, 6'h01);
        check("R7 req raised", {7'd0, int_req}, 8'h01);
        cmd(3'd0, 6'h00);
        check("R7 req dropped", {7'd0, int_req}, 8'h00);
        cmd(3'd3, 6'h0F);
    endtask

    task automatic t_prio;
        pulse(4'b1111);
        ack_read("R6 all R9", 8'h00);
        cmd(3'd3, 6'b000001);
        ack_read("R6 src1", 8'h01);
        cmd(3'd3, 6'b000010);
        ack_read("R6 src2", 8'h02);
        cmd(3'd3, 6'b000100);
        ack_read("R9 src3 base0", 8'h03);
        cmd(3'd3, 6'h0F);
    endtask

    task automatic t_base;
        cmd(3'd4, 6'h2A);
        pulse(4'b1000);
        ack_read("R9 base", 8'hAB);
        cmd(3'd3, 6'h0F);
    endtask

    task automatic t_capture;
        pulse(4'b1000);
        @(negedge clk);
        int_ack = 1'b1;
        irq_src = 4'b0000;
        @(negedge clk);
        irq_src = 4'b0001;
        @(negedge clk);
        irq_src = 4'b0000;
        check("R10 frozen after new req", vec_data, 8'hAB);
        @(negedge clk);
        check("R10 still frozen", vec_data, 8'hAB);
        int_ack = 1'b0;
        ack_read("R10 new ack", 8'hA8);
        cmd(3'd3, 6'h0F);
    endtask

    task automatic t_race;
        pulse(4'b0100);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 6'b000100; irq_src = 4'b0100;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; irq_src = '0;
        check("R3 request beats clear", {7'd0, int_status}, 8'h01);
        cmd(3'd3, 6'h0F);
    endtask

    task automatic t_unused;
        pulse(4'b0100);
        cmd(3'd5, 6'h3F);
        cmd(3'd6, 6'h3F);
        cmd(3'd7, 6'h3F);
        check("R11 status kept", {7'd0, int_status}, 8'h01);
        check("R11 enable kept", {7'd0, int_req}, 8'h00);
        ack_read("R11 vector kept", 8'hAA);
        cmd(3'd3, 6'h0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_latch();
        t_mask();
        t_ien();
        t_prio();
        t_base();
        t_capture();
        t_race();
        t_unused();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1ms;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule